// File: doc/BRIEF.md
# Buffered Link Transmitter

This block takes 16-bit words from a host through a four-phase bus write port and queues them in a 64-entry on-chip store. On the link side it emits one stored word per period of a link clock that it derives from the main clock. It moves a word only when the link partner shows it can take one. Two 2-bit sideband fields, one for error-correction hints and one for auxiliary data, are sampled and sent with each word. A pattern-select pin swaps the store for a built-in pseudo-random word source, which is useful for bring-up of the link.

The link clock is the main clock divided by eight. Two single-cycle strobes mark its rising and falling edges, so the receiver can run on the main clock with enables. Everything runs in one clock domain. Reset is active low and asynchronous.

Flow control works in both directions. On the host side, `bus_ready` is the ready signal: a transfer completes only in a cycle where the access phase sees `bus_en` and `bus_ready` both high. While the store is full, `bus_ready` stays low and the host must hold its request. On the link side, `part_rdy` is the partner's ready signal and `tx_vld` marks a fresh word. A word leaves only in a rising-strobe cycle with `part_rdy` high. Otherwise the previous word and sidebands stay on the pins.

Top module: `lnk_buf_tx`

## Requirements
- R1: While `rst_n` is low, `tx_word`, `tx_fec`, `tx_aux`, `tx_vld`, `lclk`, `lclk_rise`, `lclk_fall` and `bus_ready` are all 0.
- R2: `lclk` has a period of 8 clocks. Counting rising edges after reset release as k = 1, 2, ..., `lclk` is high after edge k when k mod 8 is 4 to 7. `lclk_rise` is high for exactly the cycles where k mod 8 = 4. `lclk_fall` is high for exactly the cycles where k mod 8 = 0 and k > 0.
- R3: A host transfer begins when `bus_sel` is seen in idle. This is followed by exactly one setup cycle and then the access phase. `bus_ready` is high in access only. The transfer completes on `bus_en && bus_ready`, after which `bus_ready` is low for one complete cycle before the block is idle again.
- R4: A completed transfer stores `bus_wdata` only if `bus_wr` is 1. A transfer with `bus_wr` = 0 completes normally and stores nothing.
- R5: The store holds 64 words. While it is full, `bus_ready` stays low in access. It rises once a word has drained.
- R6: With `pat_sel` = 0, stored words leave in write order, one per `lclk_rise` cycle in which `part_rdy` is high. `tx_word` changes on the edge that ends that cycle, and `tx_vld` is high for the following cycle only.
- R7: In a `lclk_rise` cycle with `part_rdy` low, nothing is sent. `tx_vld` stays low and `tx_word`, `tx_fec` and `tx_aux` hold.
- R8: With the store empty, a ready strobe sends nothing. The last word and sidebands hold and `tx_vld` stays low.
- R9: `tx_fec` and `tx_aux` take the values of `fec_in` and `aux_in` sampled on the same edge that loads `tx_word`, and change at no other time.
- R10: With `pat_sel` = 1, each send slot carries the next pattern word instead of a stored word, and the store is left untouched. The pattern starts at seed 16'hACE1, which is the first word sent. Each later state s is followed by {s[14:0], s[15]^s[13]^s[12]^s[10]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host select, starts a transfer |
| bus_en | input | 1 | Host enable for the access phase |
| bus_wr | input | 1 | 1 = write, 0 = read (no store) |
| bus_wdata | input | 16 | Host write word |
| bus_ready | output | 1 | Access phase can complete |
| part_rdy | input | 1 | Link partner can take a word |
| pat_sel | input | 1 | 1 = send pattern words, 0 = send stored words |
| fec_in | input | 2 | Error-correction sideband in |
| aux_in | input | 2 | Auxiliary sideband in |
| lclk | output | 1 | Link clock, clk divided by 8 |
| lclk_rise | output | 1 | One-cycle strobe at link clock rising edge |
| lclk_fall | output | 1 | One-cycle strobe at link clock falling edge |
| tx_word | output | 16 | Word on the link |
| tx_fec | output | 2 | Error-correction sideband with the word |
| tx_aux | output | 2 | Auxiliary sideband with the word |
| tx_vld | output | 1 | A new word was loaded on the last edge |

## Verification
The bench uses the default parameters: 16-bit words, a 64-entry store, a divide-by-8 link clock and the 16-bit pattern source. With these values the store fills after 64 host writes, which takes only a few hundred cycles. The full stall and its release can therefore be reached directly, and random host traffic against random partner readiness can reach them many times. A divide ratio of 8 gives enough send slots per run for every word to be compared in order, for the pattern to be checked across several steps, and for a return to stored words to show that pattern mode left the store unchanged.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_SETUP  = 2'd1,
    HS_ACCESS = 2'd2,
    HS_DONE   = 2'd3
  } host_st_e;
endpackage

// File: rtl/lbt_clkdiv.sv
// Link clock divider: counter MSB is the link clock, strobes registered.
module lbt_clkdiv #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic lclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = 1 << (DIV_LOG2 - 1);
  localparam int FULL = 1 << DIV_LOG2;
  localparam logic [DIV_LOG2-1:0] RISE_AT = DIV_LOG2'(HALF - 1);
  localparam logic [DIV_LOG2-1:0] FALL_AT = DIV_LOG2'(FULL - 1);

  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
      rise_stb <= (cnt == RISE_AT);
      fall_stb <= (cnt == FALL_AT);
    end
  end

  assign lclk = cnt[DIV_LOG2-1];
endmodule

// File: rtl/lbt_host_fsm.sv
// Four-phase host transfer control.
module lbt_host_fsm
  import lbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic en,
  input  logic wr,
  input  logic full,
  output logic ready,
  output logic wr_fire
);
  host_st_e st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      HS_IDLE:   if (sel) st_nx = HS_SETUP;
      HS_SETUP:  st_nx = HS_ACCESS;
      HS_ACCESS: if (en && ready) st_nx = HS_DONE;
      HS_DONE:   st_nx = HS_IDLE;
      default:   st_nx = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HS_IDLE;
    else        st <= st_nx;
  end

  assign ready   = (st == HS_ACCESS) && !full;
  assign wr_fire = ready && en && wr;
endmodule

// File: rtl/lbt_store.sv
// Circular word store with separate write and read pointers.
module lbt_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W:0]   fill
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign empty = (fill == '0);
  assign full  = (fill == DEPTH_V);
endmodule

// File: rtl/lbt_prbs.sv
// Fibonacci pattern source; advances only when a pattern word is taken.
module lbt_prbs #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    SEED = 16'hACE1,
  parameter logic [W-1:0]    TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] word
);
  logic fb;

  assign fb = ^(word & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= SEED;
    else if (adv) word <= {word[W-2:0], fb};
  end
endmodule

// File: rtl/lnk_buf_tx.sv
module lnk_buf_tx #(
  parameter int                DATA_W    = 16,
  parameter int                ADDR_W    = 6,
  parameter int                SB_W      = 2,
  parameter int                DIV_LOG2  = 3,
  parameter logic [DATA_W-1:0] PRBS_SEED = 16'hACE1,
  parameter logic [DATA_W-1:0] PRBS_TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  input  logic              part_rdy,
  input  logic              pat_sel,
  input  logic [SB_W-1:0]   fec_in,
  input  logic [SB_W-1:0]   aux_in,
  output logic              lclk,
  output logic              lclk_rise,
  output logic              lclk_fall,
  output logic [DATA_W-1:0] tx_word,
  output logic [SB_W-1:0]   tx_fec,
  output logic [SB_W-1:0]   tx_aux,
  output logic              tx_vld
);
  logic              wr_fire, st_full, st_empty;
  logic [DATA_W-1:0] st_rdata, pat_word;
  logic [ADDR_W:0]   fill_lvl;
  logic              slot, take_buf, take_pat;

  lbt_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .lclk     (lclk),
    .rise_stb (lclk_rise),
    .fall_stb (lclk_fall)
  );

  lbt_host_fsm u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .en      (bus_en),
    .wr      (bus_wr),
    .full    (st_full),
    .ready   (bus_ready),
    .wr_fire (wr_fire)
  );

  lbt_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_fire),
    .wdata (bus_wdata),
    .pop   (take_buf),
    .rdata (st_rdata),
    .empty (st_empty),
    .full  (st_full),
    .fill  (fill_lvl)
  );

  lbt_prbs #(.W(DATA_W), .SEED(PRBS_SEED), .TAPS(PRBS_TAPS)) u_pat (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (take_pat),
    .word  (pat_word)
  );

  assign slot     = lclk_rise && part_rdy;
  assign take_buf = slot && !pat_sel && !st_empty;
  assign take_pat = slot && pat_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_fec  <= '0;
      tx_aux  <= '0;
      tx_vld  <= 1'b0;
    end else begin
      tx_vld <= take_buf || take_pat;
      if (take_buf || take_pat) begin
        tx_word <= take_pat ? pat_word : st_rdata;
        tx_fec  <= fec_in;
        tx_aux  <= aux_in;
      end
    end
  end
endmodule

// File: rtl/lnk_buf_tx_chk.sv
module lnk_buf_tx_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int SB_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_ready,
  input logic              part_rdy,
  input logic              lclk,
  input logic              lclk_rise,
  input logic              lclk_fall,
  input logic              tx_vld,
  input logic [DATA_W-1:0] tx_word,
  input logic [SB_W-1:0]   tx_fec,
  input logic [SB_W-1:0]   tx_aux,
  input logic [ADDR_W:0]   fill
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1 << ADDR_W);

  p_rise_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lclk_rise == $rose(lclk));
  p_fall_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lclk_fall == $fell(lclk));
  p_done_after_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_en) |=> !bus_ready);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH_V);
  p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == DEPTH_V) |-> !bus_ready);
  p_send_needs_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> ($past(part_rdy) && $past(lclk_rise)));
  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld |-> $stable(tx_word));
  p_side_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_vld |-> ($stable(tx_fec) && $stable(tx_aux)));
endmodule

bind lnk_buf_tx lnk_buf_tx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SB_W(SB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_ready (bus_ready),
  .part_rdy  (part_rdy),
  .lclk      (lclk),
  .lclk_rise (lclk_rise),
  .lclk_fall (lclk_fall),
  .tx_vld    (tx_vld),
  .tx_word   (tx_word),
  .tx_fec    (tx_fec),
  .tx_aux    (tx_aux),
  .fill      (fill_lvl)
);

// File: tb/sim_lnk_buf_tx.sv
`timescale 1ns/1ps
module sim_lnk_buf_tx;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_ready;
  logic part_rdy = 1'b0, pat_sel = 1'b0;
  logic [1:0] fec_in = '0, aux_in = '0;
  logic lclk, lclk_rise, lclk_fall, tx_vld;
  logic [DW-1:0] tx_word;
  logic [1:0] tx_fec, tx_aux;

  int checks = 0, fails = 0;
  bit done = 0, mon_on = 0, rnd_rdy = 0;
  int k = 0;

  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_word = '0, pat_m = 16'hACE1;
  logic [1:0] exp_fec = '0, exp_aux = '0;
  bit exp_vld = 0;

  always #10 clk = ~clk;

  lnk_buf_tx u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .part_rdy(part_rdy), .pat_sel(pat_sel),
    .fec_in(fec_in), .aux_in(aux_in), .lclk(lclk), .lclk_rise(lclk_rise),
    .lclk_fall(lclk_fall), .tx_word(tx_word), .tx_fec(tx_fec), .tx_aux(tx_aux),
    .tx_vld(tx_vld)
  );

  function automatic logic [15:0] pat_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) k++;

  // Scoreboard: compare, then predict the next edge from sampled inputs.
  always @(negedge clk) if (mon_on) begin
    chk(lclk == ((k % 8) >= 4), "R2", "lclk", int'(lclk), int'((k % 8) >= 4));
    chk(lclk_rise == ((k % 8) == 4), "R2", "lclk_rise", int'(lclk_rise), int'((k % 8) == 4));
    chk(lclk_fall == ((k % 8) == 0 && k > 0), "R2", "lclk_fall", int'(lclk_fall),
        int'((k % 8) == 0 && k > 0));
    chk(tx_vld == exp_vld, "R7", "tx_vld", int'(tx_vld), int'(exp_vld));
    chk(tx_word == exp_word, exp_vld ? "R6" : "R8", "tx_word", int'(tx_word), int'(exp_word));
    chk(tx_fec == exp_fec && tx_aux == exp_aux, "R9", "sideband",
        int'({tx_fec, tx_aux}), int'({exp_fec, exp_aux}));
    exp_vld = 0;
    if ((k % 8) == 4 && part_rdy) begin
      if (pat_sel) begin
        exp_word = pat_m; pat_m = pat_next(pat_m); exp_vld = 1;
      end else if (q.size() > 0) begin
        exp_word = q.pop_front(); exp_vld = 1;
      end
      if (exp_vld) begin exp_fec = fec_in; exp_aux = aux_in; end
    end
    if (bus_sel && bus_en && bus_ready && bus_wr) q.push_back(bus_wdata);
  end

  // Random sideband each cycle, random partner readiness on request.
  always @(posedge clk) begin
    #2;
    fec_in = 2'($urandom());
    aux_in = 2'($urandom());
    if (rnd_rdy) part_rdy = 1'($urandom());
  end

  task automatic host_xfer(input logic [DW-1:0] d, input bit is_wr, input int exp_n);
    int n;
    @(posedge clk); #3;
    bus_sel = 1; bus_wr = is_wr; bus_wdata = d; bus_en = 0;
    @(posedge clk); #3;
    bus_en = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ready && n < 2000);
    if (exp_n > 0) chk(n == exp_n, "R3", "cycles to ready", n, exp_n);
    @(posedge clk); #3;
    bus_sel = 0; bus_en = 0;
    @(negedge clk);
    if (exp_n > 0) chk(bus_ready == 0, "R3", "ready in complete", int'(bus_ready), 0);
  endtask

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({tx_word, tx_fec, tx_aux, tx_vld, lclk, lclk_rise, lclk_fall, bus_ready} == '0,
        "R1", "reset outputs", int'(tx_word), 0);
    chk(bus_ready == 0 && lclk == 0, "R1", "reset ready/lclk", int'({bus_ready, lclk}), 0);
    @(posedge clk); #2; rst_n = 1; mon_on = 1;

    // R4/R7: stores held while partner not ready; a read stores nothing.
    host_xfer(16'h1111, 1, 2);
    host_xfer(16'hBEEF, 0, 2);
    host_xfer(16'h2222, 1, 2);
    repeat (20) @(negedge clk);
    chk(q.size() == 2, "R4", "model depth", q.size(), 2);
    @(posedge clk); #3; part_rdy = 1;
    drain();
    // R8: empty store, ready partner, strobes pass; hold checked every cycle.
    repeat (24) @(negedge clk);

    // R5: fill to capacity, then a stalled write.
    @(posedge clk); #3; part_rdy = 0;
    for (int i = 0; i < DEPTH; i++) host_xfer(16'(i * 16'h0101 + 16'h0007), 1, 2);
    @(posedge clk); #3; bus_sel = 1; bus_wr = 1; bus_wdata = 16'hF00D;
    @(posedge clk); #3; bus_en = 1;
    repeat (12) begin
      @(negedge clk);
      chk(bus_ready == 0, "R5", "ready while full", int'(bus_ready), 0);
    end
    @(posedge clk); #3; part_rdy = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ready && n < 100);
    chk(bus_ready == 1, "R5", "ready after drain", int'(bus_ready), 1);
    @(posedge clk); #3; bus_sel = 0; bus_en = 0;
    drain();

    // R10: pattern mode leaves stored words in place.
    @(posedge clk); #3; part_rdy = 0;
    host_xfer(16'hAAAA, 1, 2);
    host_xfer(16'h5555, 1, 2);
    @(posedge clk); #3; pat_sel = 1; part_rdy = 1;
    repeat (48) @(posedge clk);
    #3; pat_sel = 0;
    drain();
    chk(pat_m != 16'hACE1, "R10", "pattern advanced", int'(pat_m), 0);

    // Random host traffic against random partner readiness.
    rnd_rdy = 1;
    for (int i = 0; i < 200; i++) host_xfer(16'($urandom()), ($urandom() % 8) != 0, -1);
    rnd_rdy = 0;
    @(posedge clk); #3; part_rdy = 1;
    drain();
    chk(q.size() == 0, "R6", "all words sent", q.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule